// File: doc/BRIEF.md
# Serial Synthesizer Programming Loader

This block loads up to three external frequency synthesizers over one shared serial data line and one shared serial clock line, with a separate latch-enable line per synthesizer. A host writes a 32-bit payload as four bytes, plus three control bytes. The control bytes set the number of clock pulses, the bit order, the clock polarity, which latch line fires, and a window on a 5-bit slot counter that places the latch pulse after the last data clock. Writing the start address launches one programming cycle. A ready output drops for the length of that cycle.

Timing comes from a bit-rate enable pulse (nominally 303.75 kHz) on the system clock. Each bit slot lasts two enable pulses. In the first half, the serial clock is at its idle level and new data is presented. In the second half, the clock is at its active level. Chains longer than one cycle allows are built by running several cycles with the latch pulse suppressed and enabling it only in the final cycle.

Top module: `syn_loader`

## Requirements
- R1: Write addresses: 0 to 3 hold payload bytes, with address 0 the least significant byte. Address 4 holds latch select in bits 7:5 and the window low bound in bits 4:0. Address 5 holds the order flag in bit 5 (1 = MSB first) and the window high bound in bits 4:0. Address 6 holds clock polarity in bit 5 and the clock count in bits 4:0. A write of any value to address 7 starts a cycle.
- R2: After reset, ready is 1, the serial clock, data and all latch lines are 0, and every configuration field is 0.
- R3: A start write while ready is 1 drives ready to 0 from the next clock. The cycle runs slots 0 to L, where L = max(N-1, high bound), and N is the clock count or 1 when the count is 0. Each slot takes two bit-rate enables. Ready returns to 1 after the second enable of slot L. While ready is 1, data and latch lines are 0.
- R4: Exactly N serial clock pulses are emitted, one in each of slots 0 to N-1, so every cycle has at least one pulse.
- R5: In MSB-first order, slot s carries payload bit N-1-s. In LSB-first order, slot s carries payload bit s. The data line is 0 in slots at or above N.
- R6: With polarity 0 the clock idles low and pulses high; with polarity 1 the clock idles high and pulses low. The data line changes only at the start of a slot, so it is steady across the active half.
- R7: Select value 1, 2 or 3 drives latch line 0, 1 or 2. The line is high for every slot s with s >= N and low bound <= s <= high bound. Select values 0 and 4 to 7 suppress the latch pulse.
- R8: Every write, including a start write, is ignored while ready is 0.
- R9: The slot counter and the half-slot phase advance only on a bit-rate enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| bit_tick | input | 1 | Bit-rate enable, one clock wide |
| ser_data | output | 1 | Serial data to synthesizers |
| ser_clk | output | 1 | Serial clock to synthesizers |
| latch_en | output | 3 | Per-synthesizer latch enables |
| ready | output | 1 | High when idle and accepting writes |

## Verification
A wrong slot counter or phase shows up at the ports within one slot. It appears as an extra or missing clock pulse, a data change inside the active half, or ready returning early or late. A corrupted configuration field surfaces as a wrong received word or a latch pulse on the wrong line or in the wrong slots. That is visible by the end of the same cycle, at most 64 enables after start. A write that leaks into a running cycle is exposed by the next cycle still carrying the earlier payload.

// File: rtl/synload_pkg.sv
package synload_pkg;
  localparam int DW   = 32;            // payload width
  localparam int BW   = 8;             // host write width
  localparam int CW   = $clog2(DW);    // slot counter width
  localparam int SW   = 3;             // latch select width
  localparam int NLE  = 3;             // number of latch lines
  localparam int AW   = 3;             // write address width
  localparam int NBY  = DW / BW;       // payload bytes

  localparam logic [AW-1:0] A_SEL   = 3'd4;
  localparam logic [AW-1:0] A_ORD   = 3'd5;
  localparam logic [AW-1:0] A_POL   = 3'd6;
  localparam logic [AW-1:0] A_START = 3'd7;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [SW-1:0] sel;
    logic [CW-1:0] low;
    logic          msb;
    logic [CW-1:0] high;
    logic          pol;
    logic [CW-1:0] nclk;
  } cfg_t;
endpackage

// File: rtl/syn_regs.sv
module syn_regs
  import synload_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          busy,
  output cfg_t          cfg,
  output logic          start
);
  cfg_t cfg_q, cfg_d;
  logic acc;

  assign acc   = wr_en && !busy;
  assign start = acc && (wr_addr == A_START);

  always_comb begin
    cfg_d = cfg_q;
    if (acc) begin
      if (!wr_addr[AW-1]) begin
        cfg_d.data[wr_addr[1:0]*BW +: BW] = wr_data;
      end else begin
        case (wr_addr)
          A_SEL: begin
            cfg_d.sel = wr_data[BW-1 -: SW];
            cfg_d.low = wr_data[CW-1:0];
          end
          A_ORD: begin
            cfg_d.msb  = wr_data[CW];
            cfg_d.high = wr_data[CW-1:0];
          end
          A_POL: begin
            cfg_d.pol  = wr_data[CW];
            cfg_d.nclk = wr_data[CW-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));
endmodule

// File: rtl/syn_seq.sv
module syn_seq
  import synload_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [CW-1:0] last,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          phase
);
  logic          busy_q, busy_d, phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        cnt_d   = '0;
        phase_d = 1'b0;
      end
    end else if (tick) begin
      if (!phase_q) begin
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (cnt_q == last) busy_d = 1'b0;
        else               cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign busy  = busy_q;
  assign cnt   = cnt_q;
  assign phase = phase_q;

  // R9
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> ($stable(cnt_q) && $stable(phase_q)));
  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(start) && cnt_q == '0 && !phase_q));
  // R3
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == $past(last) && $past(tick)));
endmodule

// File: rtl/syn_out.sv
module syn_out
  import synload_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  input  logic          phase,
  output logic [CW-1:0] last,
  output logic          ser_data,
  output logic          ser_clk,
  output logic [NLE-1:0] latch_en
);
  logic [CW-1:0] neff, nm1, idx;
  logic          in_data, in_win;

  always_comb begin
    neff    = (cfg.nclk == '0) ? CW'(1) : cfg.nclk;
    nm1     = neff - CW'(1);
    last    = (nm1 >= cfg.high) ? nm1 : cfg.high;
    in_data = (cnt < neff);
    idx     = cfg.msb ? (nm1 - cnt) : cnt;
    in_win  = !in_data && (cnt >= cfg.low) && (cnt <= cfg.high);
    ser_data = busy && in_data && cfg.data[idx];
    ser_clk  = cfg.pol ^ (busy && phase && in_data);
  end

  for (genvar g = 0; g < NLE; g++) begin : g_le
    assign latch_en[g] = busy && in_win && (cfg.sel == SW'(g + 1));
  end

  // R7
  le_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_en));
  // R7
  le_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_en) |-> (ser_clk == cfg.pol));
endmodule

// File: rtl/syn_loader.sv
module syn_loader
  import synload_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [BW-1:0]  wr_data,
  input  logic           bit_tick,
  output logic           ser_data,
  output logic           ser_clk,
  output logic [NLE-1:0] latch_en,
  output logic           ready
);
  cfg_t          cfg;
  logic          start, busy, phase;
  logic [CW-1:0] cnt, last;

  syn_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .cfg(cfg), .start(start)
  );

  syn_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(bit_tick),
    .last(last), .busy(busy), .cnt(cnt), .phase(phase)
  );

  syn_out u_out (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .busy(busy), .cnt(cnt),
    .phase(phase), .last(last), .ser_data(ser_data), .ser_clk(ser_clk),
    .latch_en(latch_en)
  );

  assign ready = !busy;

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (latch_en == '0 && !ser_data));
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(phase) && phase) |-> $stable(ser_data));
endmodule

// File: tb/syn_loader_test.sv
module syn_loader_test;
  typedef struct packed {
    logic [31:0] data;
    logic [2:0]  sel;
    logic [4:0]  low;
    logic [4:0]  high;
    logic        msb;
    logic        pol;
    logic [4:0]  nclk;
    logic [7:0]  ex_steps;
    logic [5:0]  ex_pulses;
    logic [31:0] ex_word;
    logic [2:0]  ex_mask;
    logic [5:0]  ex_len;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_00A5, 3'd1, 5'd8,  5'd9,  1'b1, 1'b0, 5'd8,  8'd20, 6'd8,  32'h0000_00A5, 3'b001, 6'd2},
    '{32'h0000_0013, 3'd2, 5'd8,  5'd8,  1'b0, 1'b1, 5'd8,  8'd18, 6'd8,  32'h0000_00C8, 3'b010, 6'd1},
    '{32'hFFFF_1234, 3'd3, 5'd31, 5'd31, 1'b1, 1'b0, 5'd31, 8'd64, 6'd31, 32'h7FFF_1234, 3'b100, 6'd1},
    '{32'h0000_0001, 3'd0, 5'd1,  5'd3,  1'b1, 1'b0, 5'd0,  8'd8,  6'd1,  32'h0000_0001, 3'b000, 6'd0},
    '{32'h0000_0009, 3'd1, 5'd2,  5'd6,  1'b0, 1'b0, 5'd4,  8'd14, 6'd4,  32'h0000_0009, 3'b001, 6'd3},
    '{32'h0000_00F0, 3'd5, 5'd8,  5'd10, 1'b1, 1'b1, 5'd8,  8'd22, 6'd8,  32'h0000_00F0, 3'b000, 6'd0},
    '{32'h0000_003C, 3'd3, 5'd10, 5'd9,  1'b1, 1'b0, 5'd8,  8'd20, 6'd8,  32'h0000_003C, 3'b000, 6'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       bit_tick = 1'b0;
  logic       ser_data, ser_clk, ready;
  logic [2:0] latch_en;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  syn_loader uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bit_tick(bit_tick), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic prog(input vec_t v);
    for (int b = 0; b < 4; b++) wr(3'(b), v.data[b*8 +: 8]);
    wr(3'd4, {v.sel, v.low});
    wr(3'd5, {2'b00, v.msb, v.high});
    wr(3'd6, {2'b00, v.pol, v.nclk});
  endtask

  task automatic run_cycle(input vec_t v, input bit inject, input string tag);
    int steps = 0;
    int pulses = 0;
    int idle_bad = 0;
    int le_h [3] = '{0, 0, 0};
    int le_sum;
    logic [31:0] word = '0;
    logic [2:0]  mask;
    logic d0 = 1'b0;
    wr(3'd7, 8'h00);
    chk(ready == 1'b0, {"R3 ready low after start ", tag}, 32'(ready), 32'd0);
    while (!ready && steps < 100) begin
      if (steps % 2 == 0) begin
        if (ser_clk != v.pol) idle_bad++;
        d0 = ser_data;
      end else begin
        if (ser_data != d0) idle_bad++;
        if (ser_clk != v.pol) begin
          pulses++;
          word = {word[30:0], ser_data};
        end
      end
      for (int g = 0; g < 3; g++) le_h[g] += int'(latch_en[g]);
      if (inject && steps == 4) begin
        wr(3'd0, 8'hFF);
        wr(3'd7, 8'h00);
      end
      tick();
      steps++;
    end
    le_sum = le_h[0] + le_h[1] + le_h[2];
    for (int g = 0; g < 3; g++) mask[g] = (le_h[g] != 0);
    chk(steps == int'(v.ex_steps), {"R3 enables until ready ", tag}, 32'(steps), 32'(v.ex_steps));
    chk(pulses == int'(v.ex_pulses), {"R4 clock pulses ", tag}, 32'(pulses), 32'(v.ex_pulses));
    chk(word == v.ex_word, {"R5 R1 received word ", tag}, word, v.ex_word);
    chk(idle_bad == 0, {"R6 idle level and data hold ", tag}, 32'(idle_bad), 32'd0);
    chk(mask == v.ex_mask, {"R7 latch line ", tag}, 32'(mask), 32'(v.ex_mask));
    chk(le_sum == 2 * int'(v.ex_len), {"R7 latch half-slots ", tag}, 32'(le_sum), 32'(2 * v.ex_len));
    chk(latch_en == 3'b000 && ser_clk == v.pol && !ser_data,
        {"R3 idle after end ", tag}, {28'd0, latch_en, ser_data}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t zero_v;
    zero_v = '{32'd0, 3'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 8'd2, 6'd1, 32'd0, 3'b000, 6'd0};
    repeat (3) @(negedge clk);
    // R2: reset state at the ports
    chk(ready == 1'b1, "R2 ready after reset", 32'(ready), 32'd1);
    chk(ser_clk == 1'b0, "R2 clock after reset", 32'(ser_clk), 32'd0);
    chk(!ser_data && latch_en == 3'b000, "R2 data and latch after reset",
        {28'd0, latch_en, ser_data}, 32'd0);
    rst_n = 1'b1;
    // R9: enables while idle change nothing
    tick();
    tick();
    chk(ready == 1'b1 && ser_clk == 1'b0, "R9 idle enables ignored", {30'd0, ready, ser_clk}, 32'd2);
    // R2: cleared fields give one pulse, zero data, no latch
    run_cycle(zero_v, 1'b0, "reset-config");

    for (int i = 0; i < NV; i++) begin
      prog(VECS[i]);
      run_cycle(VECS[i], 1'b0, $sformatf("vec%0d", i));
    end

    // R8: writes and start during a cycle are ignored
    prog(VECS[0]);
    run_cycle(VECS[0], 1'b1, "inject");
    run_cycle(VECS[0], 1'b0, "R8 after-inject");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule